// File: doc/BRIEF.md
# Sampling ADC Serial Host Controller

This block runs a simultaneous-sampling 16-bit converter that sits on a serial link. It is driven from the host side. A user request carries a 16-bit configuration word. For each accepted request the controller pulses the convert strobe and waits for the converter's busy line to rise and then fall. It then opens a 16-clock frame under an active-low chip select. During that frame the configuration word goes out MSB first while the two's-complement result comes back MSB first. The result is handed to the user as a single-cycle valid pulse. Alongside the data the block returns the configuration word that governed that conversion.

A word shifted in one frame only takes hold at the next end of conversion. The converter therefore runs one conversion behind its configuration stream. The controller tracks this lag itself, so the tag on each result is the word sent two frames earlier.

Around the data path the block sequences the converter's reset and power-down pins. After a reset pulse, or after power-down is released, it waits a programmable time. It then runs one conversion whose result is thrown away, and only after that does it raise ready.

Top module: `adc_sample_host`

## Requirements
- R1: While rst_n is low: adc_cs_n is 1; adc_sck, adc_cnv, adc_din, rsp_valid, ready, adc_pd and adc_reset are all 0.
- R2: Once rst_n is released, adc_reset goes from low to high and stays high for exactly RST_CYCLES clocks. No conversion starts before it falls.
- R3: After adc_reset falls, or after pd_req is released, the first adc_cnv rise comes at least PWRUP_CYCLES clocks later. That conversion shifts the configuration word last sent (DEFAULT_CFG after reset). Its result is never reported. ready rises only after its frame ends.
- R4: Each conversion raises adc_cnv for exactly CNV_CYCLES clocks. From the strobe until busy has fallen, adc_cs_n stays high and adc_sck stays low.
- R5: A frame starts only after busy falls. It holds adc_cs_n low for exactly 16 adc_sck pulses. adc_sck idles low, and each level lasts SCLK_HALF clocks.
- R6: The configuration word goes out on adc_din MSB first. adc_din changes only while adc_sck is low, so the converter sees bit 15 at the first rising edge.
- R7: adc_sdo is sampled at each adc_sck rising edge, MSB first. The 16-bit two's-complement word is presented unchanged on rsp_data. rsp_valid is a one-cycle pulse that follows the end of the frame.
- R8: rsp_cfg carries the word shifted two frames before the frame that read the result. For the first two results after a reset it is DEFAULT_CFG.
- R9: A request that arrives during a conversion or a frame is held in one pending slot and served after the frame. A later request replaces an unserved one.
- R10: Requests made while ready is low are dropped and never produce a conversion or a result.
- R11: pd_req is acted on only while ready is high and no request is pending or in flight. adc_pd then goes high and ready low until pd_req is released, and no conversion runs meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle start request |
| req_cfg | input | 16 | Configuration word sent in the frame of this request |
| pd_req | input | 1 | Level request to power the converter down |
| ready | output | 1 | Power-up sequence done, requests accepted |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | 16 | Two's-complement conversion result |
| rsp_cfg | output | 16 | Configuration that governed this conversion |
| adc_cnv | output | 1 | Convert strobe, rising edge starts a conversion |
| adc_cs_n | output | 1 | Active-low frame enable |
| adc_sck | output | 1 | Serial clock, idle low |
| adc_din | output | 1 | Configuration bit to converter |
| adc_sdo | input | 1 | Result bit from converter |
| adc_busy | input | 1 | High while the converter is converting |
| adc_reset | output | 1 | Converter reset, active on its rising edge |
| adc_pd | output | 1 | Converter power-down |

## Verification
The bench builds the block with SCLK_HALF=2, CNV_CYCLES=3, RST_CYCLES=4 and PWRUP_CYCLES=50. With these values a full frame takes well under a hundred clocks, so a long run of conversions fits in a short run. That is enough to walk the tag chain through more than two lagged words. The short power-up wait brings two complete power sequences within reach: the one after reset and one after a power-down. Both are checked for the discarded conversion and for dropped requests. A divider of two, rather than one, makes the separate high and low phases of the serial clock visible.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
    typedef enum logic [2:0] {
        M_IDLE,
        M_CNV,
        M_BUSY_HI,
        M_BUSY_LO,
        M_FRAME
    } main_st_e;

    typedef enum logic [2:0] {
        P_INIT,
        P_RESET,
        P_WAIT,
        P_DUMMY,
        P_READY,
        P_DOWN
    } pwr_st_e;
endpackage

// File: rtl/adc_sclk_tick.sv
module adc_sclk_tick #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int HCW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HCW-1:0] LAST = HCW'(HALF - 1);

    logic [HCW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!en) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            tick  = 1'b1;
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] tx_word,
    input  logic         tick,
    input  logic         sdo,
    output logic         active,
    output logic         sck,
    output logic         din,
    output logic         done,
    output logic [W-1:0] rx_word
);
    localparam int BW = $clog2(W);
    localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

    typedef struct packed {
        logic          active;
        logic          sck;
        logic [BW-1:0] bit_cnt;
        logic [W-1:0]  tx;
        logic [W-1:0]  rx;
        logic          done;
    } fr_s;

    fr_s d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start && !q.active) begin
            d.active  = 1'b1;
            d.sck     = 1'b0;
            d.bit_cnt = '0;
            d.tx      = tx_word;
        end else if (q.active && tick) begin
            if (!q.sck) begin
                d.sck = 1'b1;
                d.rx  = {q.rx[W-2:0], sdo};
            end else begin
                d.sck = 1'b0;
                if (q.bit_cnt == LAST_BIT) begin
                    d.active = 1'b0;
                    d.done   = 1'b1;
                end else begin
                    d.bit_cnt = q.bit_cnt + 1'b1;
                    d.tx      = {q.tx[W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active  = q.active;
    assign sck     = q.sck;
    assign din     = q.active & q.tx[W-1];
    assign done    = q.done;
    assign rx_word = q.rx;

    // Serial clock never leaves idle outside a frame
    assert_sck_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !q.active |-> !q.sck);

    // Outgoing bit holds across every high phase of the serial clock
    assert_din_stable_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.sck |-> $stable(din));
endmodule

// File: rtl/adc_power_seq.sv
module adc_power_seq
    import adc_host_pkg::*;
#(
    parameter int RST_CYCLES   = 20,
    parameter int PWRUP_CYCLES = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic engine_idle,
    input  logic dummy_done,
    output logic dummy_start,
    output logic ready,
    output logic adc_reset,
    output logic adc_pd
);
    localparam int LIM = (RST_CYCLES > PWRUP_CYCLES) ? RST_CYCLES : PWRUP_CYCLES;
    localparam int CW  = $clog2(LIM + 1);
    localparam logic [CW-1:0] RST_LAST = CW'(RST_CYCLES - 1);
    localparam logic [CW-1:0] PWR_LAST = CW'(PWRUP_CYCLES - 1);

    typedef struct packed {
        pwr_st_e       st;
        logic [CW-1:0] cnt;
    } pw_s;

    pw_s d, q;

    always_comb begin
        d           = q;
        dummy_start = 1'b0;
        case (q.st)
            P_INIT: begin
                d.st  = P_RESET;
                d.cnt = '0;
            end
            P_RESET: begin
                if (q.cnt == RST_LAST) begin
                    d.st  = P_WAIT;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            P_WAIT: begin
                if (q.cnt == PWR_LAST) begin
                    dummy_start = 1'b1;
                    d.st        = P_DUMMY;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            P_DUMMY: if (dummy_done) d.st = P_READY;
            P_READY: if (pd_req && engine_idle) d.st = P_DOWN;
            P_DOWN: begin
                if (!pd_req) begin
                    d.st  = P_WAIT;
                    d.cnt = '0;
                end
            end
            default: d.st = P_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: P_INIT, cnt: '0};
        else        q <= d;
    end

    assign ready     = (q.st == P_READY);
    assign adc_reset = (q.st == P_RESET);
    assign adc_pd    = (q.st == P_DOWN);

    // Power-down only entered from a quiet engine
    assert_pd_only_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_pd) |-> $past(engine_idle));
endmodule

// File: rtl/adc_sample_host.sv
module adc_sample_host
    import adc_host_pkg::*;
#(
    parameter int              WORD_W       = 16,
    parameter int              SCLK_HALF    = 4,
    parameter int              CNV_CYCLES   = 4,
    parameter int              RST_CYCLES   = 20,
    parameter int              PWRUP_CYCLES = 20_000_000,
    parameter logic [WORD_W-1:0] DEFAULT_CFG = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_cfg,
    input  logic              pd_req,
    output logic              ready,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic [WORD_W-1:0] rsp_cfg,
    output logic              adc_cnv,
    output logic              adc_cs_n,
    output logic              adc_sck,
    output logic              adc_din,
    input  logic              adc_sdo,
    input  logic              adc_busy,
    output logic              adc_reset,
    output logic              adc_pd
);
    localparam int CCW = $clog2(CNV_CYCLES + 1);
    localparam logic [CCW-1:0] CNV_LAST = CCW'(CNV_CYCLES - 1);

    typedef struct packed {
        main_st_e          st;
        logic [CCW-1:0]    cnt;
        logic              is_dummy;
        logic [WORD_W-1:0] cur_cfg;
        logic              pend_v;
        logic [WORD_W-1:0] pend_cfg;
        logic [WORD_W-1:0] shifted;
        logic [WORD_W-1:0] applied;
        logic [WORD_W-1:0] tag;
        logic              busy;
        logic              cnv;
        logic              rsp_v;
        logic [WORD_W-1:0] rsp_data;
        logic [WORD_W-1:0] rsp_cfg;
    } host_s;

    host_s d, q;

    logic              frame_start;
    logic              frame_done;
    logic              frame_active;
    logic [WORD_W-1:0] frame_rx;
    logic              sck_tick;
    logic              dummy_start;
    logic              dummy_done;
    logic              engine_idle;

    assign engine_idle = (q.st == M_IDLE) && !q.pend_v;

    always_comb begin
        d           = q;
        d.rsp_v     = 1'b0;
        d.busy      = adc_busy;
        frame_start = 1'b0;
        dummy_done  = 1'b0;
        if (req_valid && ready) begin
            d.pend_v   = 1'b1;
            d.pend_cfg = req_cfg;
        end
        case (q.st)
            M_IDLE: begin
                if (dummy_start) begin
                    d.is_dummy = 1'b1;
                    d.cur_cfg  = q.shifted;
                    d.cnv      = 1'b1;
                    d.cnt      = '0;
                    d.st       = M_CNV;
                end else if (q.pend_v) begin
                    d.is_dummy = 1'b0;
                    d.cur_cfg  = q.pend_cfg;
                    d.pend_v   = req_valid && ready;
                    d.cnv      = 1'b1;
                    d.cnt      = '0;
                    d.st       = M_CNV;
                end
            end
            M_CNV: begin
                if (q.cnt == CNV_LAST) begin
                    d.cnv = 1'b0;
                    d.st  = M_BUSY_HI;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            M_BUSY_HI: if (q.busy) d.st = M_BUSY_LO;
            M_BUSY_LO: begin
                if (!q.busy) begin
                    d.tag       = q.applied;
                    d.applied   = q.shifted;
                    d.shifted   = q.cur_cfg;
                    frame_start = 1'b1;
                    d.st        = M_FRAME;
                end
            end
            M_FRAME: begin
                if (frame_done) begin
                    if (!q.is_dummy) begin
                        d.rsp_v    = 1'b1;
                        d.rsp_data = frame_rx;
                        d.rsp_cfg  = q.tag;
                    end
                    dummy_done = q.is_dummy;
                    d.st       = M_IDLE;
                end
            end
            default: d.st = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= M_IDLE;
            q.cur_cfg  <= DEFAULT_CFG;
            q.shifted  <= DEFAULT_CFG;
            q.applied  <= DEFAULT_CFG;
            q.tag      <= DEFAULT_CFG;
        end else begin
            q <= d;
        end
    end

    adc_sclk_tick #(.HALF(SCLK_HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (frame_active),
        .tick  (sck_tick)
    );

    adc_frame_shift #(.W(WORD_W)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (frame_start),
        .tx_word (q.cur_cfg),
        .tick    (sck_tick),
        .sdo     (adc_sdo),
        .active  (frame_active),
        .sck     (adc_sck),
        .din     (adc_din),
        .done    (frame_done),
        .rx_word (frame_rx)
    );

    adc_power_seq #(
        .RST_CYCLES   (RST_CYCLES),
        .PWRUP_CYCLES (PWRUP_CYCLES)
    ) u_pwr (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_req      (pd_req),
        .engine_idle (engine_idle),
        .dummy_done  (dummy_done),
        .dummy_start (dummy_start),
        .ready       (ready),
        .adc_reset   (adc_reset),
        .adc_pd      (adc_pd)
    );

    assign adc_cs_n  = ~frame_active;
    assign adc_cnv   = q.cnv;
    assign rsp_valid = q.rsp_v;
    assign rsp_data  = q.rsp_data;
    assign rsp_cfg   = q.rsp_cfg;

    // Serial link stays quiet from strobe until busy has dropped
    assert_quiet_in_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == M_CNV || q.st == M_BUSY_HI || q.st == M_BUSY_LO) |-> (adc_cs_n && !adc_sck));

    // Strobe never overlaps an open frame
    assert_cnv_outside_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cnv |-> adc_cs_n);

    // Results only reach the user once the converter is ready
    assert_rsp_when_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ready);

    // Result strobe lasts a single cycle
    assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: tb/adc_sample_host_tb.sv
`timescale 1ns/1ps
module adc_sample_host_tb;
    localparam int HALF  = 2;
    localparam int CNVC  = 3;
    localparam int RSTC  = 4;
    localparam int PWR   = 50;
    localparam int BUSYC = 6;
    localparam logic [15:0] DEF = 16'h3C5A;
    localparam int NV = 8;
    // {cfg word, converter result}
    localparam logic [31:0] VEC [NV] = '{
        32'h1021_8000, 32'h2042_7FFF, 32'h4084_FFFF, 32'h8108_0000,
        32'h0210_A5A5, 32'h0420_0001, 32'h0840_5A5A, 32'hF00F_C3C3
    };

    logic clk = 1'b0;
    logic rst_n, req_valid, pd_req;
    logic [15:0] req_cfg;
    logic ready, rsp_valid, adc_cnv, adc_cs_n, adc_sck, adc_din, adc_reset, adc_pd;
    logic [15:0] rsp_data, rsp_cfg;
    logic adc_sdo, adc_busy;

    adc_sample_host #(
        .WORD_W(16), .SCLK_HALF(HALF), .CNV_CYCLES(CNVC),
        .RST_CYCLES(RSTC), .PWRUP_CYCLES(PWR), .DEFAULT_CFG(DEF)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cfg(req_cfg),
        .pd_req(pd_req), .ready(ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_cfg(rsp_cfg), .adc_cnv(adc_cnv), .adc_cs_n(adc_cs_n), .adc_sck(adc_sck),
        .adc_din(adc_din), .adc_sdo(adc_sdo), .adc_busy(adc_busy),
        .adc_reset(adc_reset), .adc_pd(adc_pd)
    );

    initial forever #2.5 clk = ~clk;

    int n_checks = 0;
    int n_errs   = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    logic [15:0] tab [0:63];
    logic [15:0] m_tx, m_rx;
    int m_conv = 0, m_bits = 0, quiet_bad = 0, cnv_len = 0;
    logic [15:0] frm_word [0:63];
    int frm_bits [0:63];
    int frm_n = 0;
    logic [15:0] rsp_d [0:63];
    logic [15:0] rsp_t [0:63];
    int rsp_c [0:63];
    int rsp_n = 0;

    initial begin
        adc_busy = 1'b0;
        adc_sdo  = 1'b0;
        m_tx     = '0;
        forever begin
            @(posedge adc_cnv);
            @(negedge clk);
            adc_busy = 1'b1;
            repeat (BUSYC) @(negedge clk);
            m_tx     = tab[m_conv];
            adc_sdo  = m_tx[15];
            adc_busy = 1'b0;
            m_conv++;
        end
    end

    initial forever begin
        @(negedge adc_sck);
        m_tx    = {m_tx[14:0], 1'b0};
        adc_sdo = m_tx[15];
    end

    initial begin
        m_rx = '0;
        forever begin
            @(posedge adc_sck);
            m_rx = {m_rx[14:0], adc_din};
            m_bits++;
        end
    end

    initial forever begin
        @(posedge adc_cs_n);
        if (m_bits != 0) begin
            frm_word[frm_n] = m_rx;
            frm_bits[frm_n] = m_bits;
            frm_n++;
            m_bits = 0;
        end
    end

    initial forever begin
        @(negedge clk);
        if (adc_busy && (adc_sck || !adc_cs_n)) quiet_bad++;
        if (rsp_valid) begin
            rsp_d[rsp_n] = rsp_data;
            rsp_t[rsp_n] = rsp_cfg;
            rsp_c[rsp_n] = m_conv;
            rsp_n++;
        end
    end

    initial forever begin
        int l;
        @(posedge adc_cnv);
        l = 0;
        @(negedge clk);
        while (adc_cnv) begin
            l++;
            @(negedge clk);
        end
        cnv_len = l;
    end

    // ---------------- helpers ----------------
    task automatic send_req(input logic [15:0] c);
        @(negedge clk);
        req_valid = 1'b1;
        req_cfg   = c;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_rsp(input int n);
        while (rsp_n < n) @(negedge clk);
    endtask

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int cnt, base, c0, f0;
        for (int n = 0; n < 64; n++) tab[n] = 16'(n * 16'h1F3D) ^ 16'h8421;
        tab[0] = 16'hDEAD;
        for (int i = 0; i < NV; i++) tab[i+1] = VEC[i][15:0];

        rst_n = 1'b0; req_valid = 1'b0; req_cfg = '0; pd_req = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(adc_cs_n === 1'b1 && adc_sck === 1'b0 && adc_cnv === 1'b0 && adc_din === 1'b0,
            "R1 link idle", {adc_cs_n, adc_sck, adc_cnv, adc_din}, 4'b1000);
        chk(rsp_valid === 1'b0 && ready === 1'b0 && adc_pd === 1'b0 && adc_reset === 1'b0,
            "R1 status low", {rsp_valid, ready, adc_pd, adc_reset}, 0);
        rst_n = 1'b1;

        // R2 reset pulse length
        while (!adc_reset) @(negedge clk);
        cnt = 0;
        while (adc_reset) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == RSTC, "R2 reset pulse length", cnt, RSTC);
        chk(m_conv == 0, "R2 no conversion before reset falls", m_conv, 0);

        // R3 power-up wait
        cnt = 0;
        while (!adc_cnv) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt >= PWR, "R3 wait before dummy", cnt, PWR);
        wait_ready();
        chk(m_conv == 1, "R3 one dummy conversion", m_conv, 1);
        chk(rsp_n == 0, "R3 dummy result unreported", rsp_n, 0);
        chk(frm_word[0] == DEF, "R3 dummy shifts default cfg", frm_word[0], DEF);
        chk(cnv_len == CNVC, "R4 strobe width", cnv_len, CNVC);

        // table of vectors: R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            logic [15:0] exp_tag;
            base = rsp_n;
            send_req(VEC[i][31:16]);
            wait_rsp(base + 1);
            exp_tag = (i < 2) ? DEF : VEC[i-2][31:16];
            chk(rsp_d[base] == VEC[i][15:0], "R7 result data", rsp_d[base], VEC[i][15:0]);
            chk(rsp_t[base] == exp_tag, "R8 config tag", rsp_t[base], exp_tag);
            chk(frm_word[frm_n-1] == VEC[i][31:16], "R6 cfg MSB first", frm_word[frm_n-1], VEC[i][31:16]);
            chk(frm_bits[frm_n-1] == 16, "R5 sixteen clocks", frm_bits[frm_n-1], 16);
        end

        // R9 pending slot, newest wins
        base = rsp_n;
        f0   = frm_n;
        send_req(16'h1357);
        @(posedge adc_busy);
        send_req(16'h2468);
        send_req(16'h9ABC);
        wait_rsp(base + 2);
        repeat (300) @(negedge clk);
        chk(rsp_n == base + 2, "R9 two results", rsp_n, base + 2);
        chk(frm_word[f0] == 16'h1357, "R9 first frame", frm_word[f0], 16'h1357);
        chk(frm_word[f0+1] == 16'h9ABC, "R9 newest pending served", frm_word[f0+1], 16'h9ABC);
        chk(rsp_t[base] == VEC[6][31:16], "R8 tag after table", rsp_t[base], VEC[6][31:16]);
        chk(rsp_t[base+1] == VEC[7][31:16], "R8 tag second", rsp_t[base+1], VEC[7][31:16]);
        chk(rsp_d[base+1] == tab[rsp_c[base+1]-1], "R7 pending data", rsp_d[base+1], tab[rsp_c[base+1]-1]);

        // R11 power-down, R10 dropped requests
        @(negedge clk);
        pd_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(adc_pd === 1'b1 && ready === 1'b0, "R11 powered down", {adc_pd, ready}, 2'b10);
        c0   = m_conv;
        base = rsp_n;
        send_req(16'h7777);
        repeat (20) @(negedge clk);
        chk(m_conv == c0 && adc_cs_n === 1'b1, "R11 no conversion while down", m_conv, c0);
        pd_req = 1'b0;
        wait_ready();
        chk(m_conv == c0 + 1, "R3 dummy after power-down", m_conv, c0 + 1);
        repeat (200) @(negedge clk);
        chk(rsp_n == base, "R10 request while not ready dropped", rsp_n, base);
        chk(m_conv == c0 + 1, "R10 no extra conversion", m_conv, c0 + 1);

        send_req(16'h4242);
        wait_rsp(base + 1);
        chk(rsp_d[base] == tab[rsp_c[base]-1], "R7 data after power-up", rsp_d[base], tab[rsp_c[base]-1]);
        chk(quiet_bad == 0, "R4 link quiet while busy", quiet_bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule